// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block is the producer end of an interrupt ring that lives in system memory. Interrupt events arrive with a source id, 28 bits of source data, a ring id, a VMID and a PASID. Each accepted event is packed into one 128-bit vector. The vector is written to the ring at the current write pointer, and the pointer then steps forward by one entry. The host consumes entries and reports how far it has read by writing the read pointer. The block asserts an interrupt while unread entries remain.

A small register port configures the block. It sets the ring base, the ring size, the enables, the host read pointer and the overflow handling. It also returns the write pointer, with a sticky overflow flag in its lowest bit. When the ring is full, the writer keeps going and overwrites the oldest entry, and the overflow flag records that this happened. After every vector, the block can also store the new pointer value at a second memory address that the host chooses.

Top module: `ivring_writer`

## Requirements
- R1: An accepted event (`ev_valid` and `ev_ready` high at a clock edge) produces, after that edge, one 128-bit write (`mem_we`=1, `mem_wide`=1). The write goes to address {BASE,8'h00} + write pointer. Its data holds the source id in [7:0], the source data in [59:32], the ring id in [71:64], the VMID in [79:72] and the PASID in [95:80], with all other bits zero.
- R2: Pointers count in bytes, and the write pointer advances by 16 per accepted event. It wraps with mask (4 << S) − 1, where S is CTRL[5:1], the ring size as log2 of 32-bit words. S is clamped to the range 3 to MAX_LOG2W.
- R3: Interrupt-enable is CTRL[9]. With re-arm off, `irq` is high one clock after the read and write pointers differ or the overflow flag is set, and low one clock after neither is true.
- R4: The ring is full when (write pointer + 16) masked equals the read pointer. A write into a full ring still takes place. If overflow detection (CTRL[6]) is on, it also sets the overflow flag, which reads back as bit 0 of the WPTR register.
- R5: Writing CTRL with bit 7 set clears the overflow flag. Bit 7 is not stored and reads back as 0.
- R6: With writeback enabled (CTRL[8]), the clock after each vector write carries one narrow write (`mem_wide`=0). It goes to {WB_HI[7:0], WB_LO[31:2], 2'b00}, and its data is the WPTR read-back value. `ev_ready` is low during that slot.
- R7: When ring-enable (CTRL[0]) is low, `ev_ready` is low and no vector is written. WPTR accepts host writes only while the ring is disabled; writes to WPTR while the ring is enabled are ignored.
- R8: Re-arm mode (CTRL[10]) is for message-signalled delivery, and in it `irq` is a one-cycle pulse. A pulse fires one clock after the ring goes from idle to pending. A pulse also fires one clock after a host write to RPTR that leaves entries pending.
- R9: After reset, all registers read zero and `ev_ready`, `irq` and `mem_we` are low.
- R10: With overflow detection off, writing into a full ring leaves the overflow flag clear.
- R11: The register offsets are: 0 CTRL, 1 BASE (ring address >> 8), 2 RPTR, 3 WPTR, 4 WB_LO, 5 WB_HI. `reg_rdata` returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vmid | input | 8 | VMID |
| ev_pasid | input | 16 | PASID |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mem_we | output | 1 | Memory write strobe |
| mem_wide | output | 1 | 1: 128-bit vector, 0: 32-bit pointer writeback |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 128 | Memory write data |
| irq | output | 1 | Interrupt request to the host |

## Verification
The vector write shows up on the memory port one clock after the accepting edge, and the writeback one clock after that. The write-pointer read-back is already updated after the accepting edge, while `irq` moves one edge later than the pointer state it depends on. The bench drives inputs on falling edges and samples on the falling edge that follows the register stage of each result. Each check waits exactly one or two falling edges after its stimulus, as the timing above requires. Re-arm pulses are checked on their cycle and on the cycle after, to confirm they last only one clock.

// File: rtl/ivring_writer.sv
module ivring_writer #(
  parameter int MAX_LOG2W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_valid,
  output logic         ev_ready,
  input  logic [7:0]   ev_src,
  input  logic [27:0]  ev_data,
  input  logic [7:0]   ev_ring,
  input  logic [7:0]   ev_vmid,
  input  logic [15:0]  ev_pasid,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  output logic         mem_we,
  output logic         mem_wide,
  output logic [39:0]  mem_addr,
  output logic [127:0] mem_wdata,
  output logic         irq
);
  localparam int PW = MAX_LOG2W + 2;
  localparam logic [2:0] A_CTRL = 3'd0, A_BASE = 3'd1, A_RPTR = 3'd2,
                         A_WPTR = 3'd3, A_WBLO = 3'd4, A_WBHI = 3'd5;

  logic          ring_en, ovf_en, wb_en, irq_en, rearm_en;
  logic [4:0]    sz;
  logic [31:0]   base;
  logic [PW-1:0] rptr, wptr;
  logic          ovf;
  logic [31:2]   wb_lo;
  logic [7:0]    wb_hi;
  logic          wb_pend, pend_q, rptr_wr_d;

  logic [4:0]    sz_eff;
  logic [PW-1:0] mask, wnext;
  logic          accept, full, pend, ctrl_wr, wptr_wr, rptr_wr;
  logic [PW-1:0] wrb;

  assign sz_eff  = (sz < 5'd3) ? 5'd3 : ((sz > 5'(MAX_LOG2W)) ? 5'(MAX_LOG2W) : sz);
  assign mask    = PW'((32'd1 << (sz_eff + 5'd2)) - 32'd1);
  assign wnext   = (wptr + PW'(16)) & mask;
  assign full    = (wnext == rptr);
  assign ev_ready = ring_en & ~wb_pend;
  assign accept  = ev_valid & ev_ready;
  assign pend    = (rptr != wptr) | ovf;
  assign ctrl_wr = reg_we && reg_addr == A_CTRL;
  assign wptr_wr = reg_we && reg_addr == A_WPTR && !ring_en;
  assign rptr_wr = reg_we && reg_addr == A_RPTR;
  assign wrb     = {wptr[PW-1:1], ovf};

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {21'd0, rearm_en, irq_en, wb_en, 1'b0, ovf_en, sz, ring_en};
      A_BASE:  reg_rdata = base;
      A_RPTR:  reg_rdata = 32'(rptr);
      A_WPTR:  reg_rdata = 32'(wrb);
      A_WBLO:  reg_rdata = {wb_lo, 2'b00};
      A_WBHI:  reg_rdata = {24'd0, wb_hi};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_en <= 1'b0; ovf_en <= 1'b0; wb_en <= 1'b0; irq_en <= 1'b0; rearm_en <= 1'b0;
      sz <= '0; base <= '0; rptr <= '0; wb_lo <= '0; wb_hi <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin
          ring_en  <= reg_wdata[0];
          sz       <= reg_wdata[5:1];
          ovf_en   <= reg_wdata[6];
          wb_en    <= reg_wdata[8];
          irq_en   <= reg_wdata[9];
          rearm_en <= reg_wdata[10];
        end
        A_BASE: base  <= reg_wdata;
        A_RPTR: rptr  <= {reg_wdata[PW-1:4], 4'd0};
        A_WBLO: wb_lo <= reg_wdata[31:2];
        A_WBHI: wb_hi <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      ovf  <= 1'b0;
    end else begin
      if (accept) wptr <= wnext;
      else if (wptr_wr) wptr <= {reg_wdata[PW-1:4], 4'd0};
      if (accept && full && ovf_en) ovf <= 1'b1;
      else if ((ctrl_wr && reg_wdata[7]) || wptr_wr) ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we <= 1'b0; mem_wide <= 1'b0; mem_addr <= '0; mem_wdata <= '0; wb_pend <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (accept) begin
        mem_we    <= 1'b1;
        mem_wide  <= 1'b1;
        mem_addr  <= {base, 8'd0} + {{(40-PW){1'b0}}, wptr};
        mem_wdata <= {32'd0, ev_pasid, ev_vmid, ev_ring, 4'd0, ev_data, 24'd0, ev_src};
        wb_pend   <= wb_en;
      end else if (wb_pend) begin
        mem_we    <= 1'b1;
        mem_wide  <= 1'b0;
        mem_addr  <= {wb_hi, wb_lo, 2'b00};
        mem_wdata <= {{(128-PW){1'b0}}, wrb};
        wb_pend   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0; pend_q <= 1'b0; rptr_wr_d <= 1'b0;
    end else begin
      pend_q    <= pend;
      rptr_wr_d <= rptr_wr;
      if (rearm_en) irq <= irq_en & pend & (~pend_q | rptr_wr_d);
      else          irq <= irq_en & pend;
    end
  end

  AST_VEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_we && mem_wide && mem_wdata[31:8] == 24'd0 && mem_wdata[127:96] == 32'd0); // R1
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wptr == (($past(wptr) + PW'(16)) & $past(mask))); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(ctrl_wr && reg_wdata[7]) && !wptr_wr) |=> ovf); // R5
  AST_WB_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pend |=> mem_we && !mem_wide); // R6
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ring_en && !wb_pend) |=> !mem_we); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pend)); // R3
endmodule

// File: tb/ivring_writer_tb.sv
`timescale 1ns/1ps
module ivring_writer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_ready;
  logic [7:0] ev_src = '0, ev_ring = '0, ev_vmid = '0;
  logic [27:0] ev_data = '0;
  logic [15:0] ev_pasid = '0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_we, mem_wide, irq;
  logic [39:0] mem_addr;
  logic [127:0] mem_wdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ivring_writer u_dut (.clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring), .ev_vmid(ev_vmid), .ev_pasid(ev_pasid),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq));

  typedef struct packed {
    logic [7:0] src; logic [27:0] data; logic [7:0] ring; logic [7:0] vmid; logic [15:0] pasid;
    logic [15:0] exp_wptr_rb;
  } vec_t;
  localparam vec_t TBL [4] = '{
    '{8'h21, 28'hABCDEF1, 8'h05, 8'h01, 16'h1234, 16'd16},
    '{8'hFF, 28'hFFFFFFF, 8'hFF, 8'hFF, 16'hFFFF, 16'd32},
    '{8'h00, 28'h0000000, 8'h00, 8'h00, 16'h0000, 16'd48},
    '{8'h7C, 28'h5A5A5A5, 8'h3E, 8'h0F, 16'hBEEF, 16'd1}
  };
  localparam logic [39:0] RING = 40'h0001234500;

  function automatic logic [127:0] pack(input logic [7:0] s, input logic [27:0] d,
      input logic [7:0] r, input logic [7:0] v, input logic [15:0] p);
    logic [127:0] x = '0;
    x[7:0] = s; x[59:32] = d; x[71:64] = r; x[79:72] = v; x[95:80] = p;
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rchk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #0.5;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic push(input logic [7:0] s, input logic [27:0] d, input logic [7:0] r,
      input logic [7:0] v, input logic [15:0] p, input logic [39:0] ea, input string tag);
    @(negedge clk);
    chk(ev_ready, {tag, " ready"}, ev_ready, 1);
    ev_valid = 1'b1; ev_src = s; ev_data = d; ev_ring = r; ev_vmid = v; ev_pasid = p;
    @(negedge clk); ev_valid = 1'b0;
    chk(mem_we && mem_wide, {tag, " R1 strobe"}, {mem_we, mem_wide}, 2'b11);
    chk(mem_addr == ea, {tag, " R1 addr"}, mem_addr, ea);
    chk(mem_wdata == pack(s, d, r, v, p), {tag, " R1 data"}, mem_wdata, pack(s, d, r, v, p));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] wp;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!ev_ready && !irq && !mem_we, "R9 outputs", {ev_ready, irq, mem_we}, 0);
    rchk(3'd0, 0, "R9 ctrl");
    rchk(3'd3, 0, "R9 wptr");
    rst_n = 1'b1;
    wreg(3'd1, 32'h12345);
    wreg(3'd0, 32'd585);                 // en, S=4, ovf_en, irq_en
    rchk(3'd0, 32'd585, "R11 ctrl readback");
    rchk(3'd1, 32'h12345, "R11 base readback");
    wp = 0;
    foreach (TBL[i]) begin
      push(TBL[i].src, TBL[i].data, TBL[i].ring, TBL[i].vmid, TBL[i].pasid, RING + 40'(wp), "R1 R4 table");
      @(negedge clk);
      rchk(3'd3, 32'(TBL[i].exp_wptr_rb), "R2 R4 wptr readback");
      chk(irq, "R3 irq pending", irq, 1);
      wp = TBL[i].exp_wptr_rb & 16'hFFF0;
    end
    wreg(3'd0, 32'd585 | 32'd128);
    rchk(3'd3, 0, "R5 ovf cleared");
    rchk(3'd0, 32'd585, "R5 clear bit not stored");
    @(negedge clk);
    chk(!irq, "R3 irq idle", irq, 0);
    wreg(3'd2, 32'd16);
    rchk(3'd2, 32'd16, "R11 rptr readback");
    @(negedge clk);
    chk(irq, "R3 irq on rptr diff", irq, 1);
    wreg(3'd2, 32'd0);
    @(negedge clk);
    chk(!irq, "R3 irq drop", irq, 0);
    // R6 writeback
    wreg(3'd4, 32'h1000);
    wreg(3'd5, 32'hAB);
    wreg(3'd0, 32'd841);
    push(8'h11, 28'h22, 8'h33, 8'h44, 16'h5555, RING, "R6 vec");
    chk(!ev_ready, "R6 ready low in wb slot", ev_ready, 0);
    @(negedge clk);
    chk(mem_we && !mem_wide, "R6 wb strobe", {mem_we, mem_wide}, 2'b10);
    chk(mem_addr == 40'hAB00001000, "R6 wb addr", mem_addr, 40'hAB00001000);
    chk(mem_wdata == 128'd16, "R6 wb data", mem_wdata, 16);
    // R7 disabled behaviour
    wreg(3'd3, 32'd48);
    rchk(3'd3, 32'd16, "R7 wptr write ignored when enabled");
    wreg(3'd0, 32'd0);
    chk(!ev_ready, "R7 ready low", ev_ready, 0);
    ev_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!mem_we, "R7 no write when disabled", mem_we, 0);
    end
    ev_valid = 1'b0;
    wreg(3'd3, 32'd0);
    wreg(3'd2, 32'd0);
    rchk(3'd3, 0, "R7 wptr reset while disabled");
    // R10 overflow detection off, 2-entry ring
    wreg(3'd0, 32'd7);
    push(8'h01, 28'h1, 8'h1, 8'h1, 16'h1, RING, "R10 first");
    push(8'h02, 28'h2, 8'h2, 8'h2, 16'h2, RING + 40'd16, "R10 full write");
    rchk(3'd3, 0, "R10 no flag");
    // R8 re-arm
    wreg(3'd0, 32'd0);
    wreg(3'd3, 32'd0);
    wreg(3'd0, 32'd1545);
    chk(!irq, "R8 idle", irq, 0);
    push(8'h09, 28'h9, 8'h9, 8'h9, 16'h9, RING, "R8 event");
    @(negedge clk);
    chk(irq, "R8 pulse on pending", irq, 1);
    @(negedge clk);
    chk(!irq, "R8 pulse one cycle", irq, 0);
    wreg(3'd2, 32'd0);
    @(negedge clk);
    chk(irq, "R8 re-arm on rptr write", irq, 1);
    @(negedge clk);
    chk(!irq, "R8 re-arm pulse ends", irq, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule